// File: doc/BRIEF.md
# Microphone Capture Receive FIFO and Interrupt Register Block

This block is the capture-side register file of a multichannel pulse-density microphone interface. Upstream decimation logic produces 24-bit samples. Each sample carries the index of the channel it came from, and the producer offers it on a valid/ready port. The block queues the samples in a small FIFO. A processor or DMA engine drains them through a holding register. Each word it reads carries the sample in the low 24 bits and the channel index in the top byte.

Software reaches the block through a simple 32-bit register port. A read is accepted in the idle state of a two-state access machine, which has the states BUS_IDLE and BUS_RESP. The transition BUS_IDLE to BUS_RESP happens on an accepted read. The transition BUS_RESP to BUS_IDLE always happens on the next clock. A write is accepted in BUS_IDLE and leaves the machine in BUS_IDLE.

Six interrupt sources are reported. Four of them are live FIFO levels: ready, empty, full and chunk. Two are sticky error events: underrun and overrun. The interrupt mask is set through one write-one register and cleared through another. A chunk threshold in the mode register drives a DMA request level. A control register offers a soft reset that empties the queue.

Top module: `mic_rx_regs`

## Requirements
- R1: After reset, bus_rdata is 0 and irq is low. dma_req is low, smp_ready and bus_ready are high, and the status register reads 0x02 (only the empty bit set).
- R2: A read of the holding register at 0x0C returns the oldest queued sample. The sample is in bits 23:0 and the channel index, zero-extended, is in bits 31:24. The read removes that entry, so samples come out in the order they were accepted.
- R3: The FIFO holds 16 entries. With 16 entries stored, status bit 2 (full) is set and smp_ready is low. Sixteen holding reads drain the FIFO back to empty.
- R4: An offer on smp_valid while the FIFO is full drops the sample and latches status bit 5 (overrun).
- R5: A holding read while the FIFO is empty returns 0 and latches status bit 4 (underrun).
- R6: Writing ones to 0x14 sets those mask bits and writing ones to 0x18 clears them. The mask reads back at 0x1C in bits 5:0. Writes to 0x1C are ignored.
- R7: irq is high exactly when the bitwise AND of the status and the mask is nonzero.
- R8: Status at 0x20 has these bits: bit 0 is ready (FIFO not empty), bit 1 is empty, bit 2 is full and bit 3 is chunk; these four are live levels. Reading 0x20 clears latched bits 4 and 5. If an error event falls on the same clock edge as that clearing read, the bit ends up set.
- R9: Mode register bits 31:28 hold a chunk threshold, where a value of 0 acts as 1. Status bit 3 and dma_req are high while the FIFO holds at least that many entries.
- R10: Writing 1 to bit 0 of the control register at 0x00 empties the FIFO and clears the latched status bits. The mask, mode and config registers keep their values. The control register reads as 0.
- R11: The register at 0x50 returns the VERSION parameter in bits 11:0 and 0 above.
- R12: Mode (0x04) and config (0x08) read back the full written word. Addresses outside the readable set (0x00, 0x14, 0x18, unmapped) read 0.
- R13: Read data and bus_rvalid appear in the cycle after the read is accepted. bus_rvalid lasts one cycle, and bus_ready is low during that cycle. Register side effects take place at the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access can be accepted this cycle |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid pulse |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | FIFO level at or above chunk threshold |
| smp_valid | input | 1 | Producer offers a sample |
| smp_ready | output | 1 | FIFO can accept a sample |
| smp_data | input | 24 | Sample value |
| smp_chan | input | CHAN_W | Channel index of the sample |

## Verification
The two functions that can meet on one clock edge are clearing the sticky status bits by a read of 0x20, and latching a new overrun from a sample offered into a full FIFO. The bench fills the FIFO and then, in a single cycle, issues the status read and raises smp_valid. That read must return 0x0D, because the overrun is not yet visible. A second status read must then return 0x2D, which shows that the new event won over the clear. A soft reset applied with the FIFO full and overrun latched is judged the same way, by reading status, mask and mode afterwards.

// File: rtl/mic_rx_pkg.sv
package mic_rx_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int SAMPLE_W = 24;
    localparam int TAG_W    = DATA_W - SAMPLE_W;

    // register offsets
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_MODE  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_CFG   = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_HOLD  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_IEN   = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_IDIS  = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_IMASK = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_ISTAT = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_VER   = 8'h50;

    // interrupt source positions
    localparam int IB_RDY   = 0;
    localparam int IB_EMP   = 1;
    localparam int IB_FULL  = 2;
    localparam int IB_CHUNK = 3;
    localparam int IB_UDR   = 4;
    localparam int IB_OVR   = 5;
    localparam int IRQ_N    = 6;

    // chunk threshold field in the mode word
    localparam int CHUNK_LSB = 28;
    localparam int CHUNK_W   = 4;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic soft_rst;
        logic ien_wr;
        logic idis_wr;
        logic hold_rd;
        logic stat_rd;
    } acc_strobe_t;

endpackage

// File: rtl/mic_rx_fifo.sv
module mic_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 26
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic                           push_valid,
    input  logic [WIDTH-1:0]               push_data,
    output logic                           push_ready,
    input  logic                           pop,
    output logic [WIDTH-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           empty,
    output logic                           full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign full       = (cnt_q == CNT_W'(DEPTH));
    assign empty      = (cnt_q == '0);
    assign push_ready = !full;
    assign do_push    = push_valid && !full && !flush;
    assign do_pop     = pop && !empty && !flush;
    assign head       = mem[rd_ptr];
    assign count      = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R3
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)
                   || (cnt_q + 1'b1 == $past(cnt_q)));

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !flush) |=> full);

endmodule

// File: rtl/mic_rx_irq.sv
module mic_rx_irq
    import mic_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             ien_wr,
    input  logic             idis_wr,
    input  logic [IRQ_N-1:0] wbits,
    input  logic             stat_rd,
    input  logic             lvl_rdy,
    input  logic             lvl_emp,
    input  logic             lvl_full,
    input  logic             lvl_chunk,
    input  logic             udr_evt,
    input  logic             ovr_evt,
    output logic [IRQ_N-1:0] mask,
    output logic [IRQ_N-1:0] status,
    output logic             irq
);
    logic [IRQ_N-1:0] mask_q;
    logic             udr_q, ovr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (ien_wr) begin
            mask_q <= mask_q | wbits;
        end else if (idis_wr) begin
            mask_q <= mask_q & ~wbits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            udr_q <= 1'b0;
            ovr_q <= 1'b0;
        end else if (flush) begin
            udr_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            udr_q <= (udr_q && !stat_rd) || udr_evt;
            ovr_q <= (ovr_q && !stat_rd) || ovr_evt;
        end
    end

    always_comb begin
        status           = '0;
        status[IB_RDY]   = lvl_rdy;
        status[IB_EMP]   = lvl_emp;
        status[IB_FULL]  = lvl_full;
        status[IB_CHUNK] = lvl_chunk;
        status[IB_UDR]   = udr_q;
        status[IB_OVR]   = ovr_q;
    end

    assign mask = mask_q;
    assign irq  = |(status & mask_q);

    // R6
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ien_wr |=> ((mask_q & $past(wbits)) == $past(wbits)));

    // R6
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idis_wr && !ien_wr) |=> ((mask_q & $past(wbits)) == '0));

    // R8
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !ovr_evt && !flush) |=> !ovr_q);

    // R8
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_evt && !flush) |=> ovr_q);

endmodule

// File: rtl/mic_rx_bus.sv
module mic_rx_bus
    import mic_rx_pkg::*;
#(
    parameter logic [11:0] VERSION = 12'h2C5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic               bus_ready,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_rvalid,
    input  logic [DATA_W-1:0]  hold_word,
    input  logic               fifo_empty,
    input  logic [IRQ_N-1:0]   mask,
    input  logic [IRQ_N-1:0]   status,
    output acc_strobe_t        strobe,
    output logic [CHUNK_W-1:0] chunk_code
);
    bus_state_e        state_q, state_d;
    logic              acc_rd, acc_wr;
    logic [DATA_W-1:0] mode_q, cfg_q, rd_mux, rdata_q;

    assign acc_rd = bus_sel && !bus_wr && (state_q == BUS_IDLE);
    assign acc_wr = bus_sel &&  bus_wr && (state_q == BUS_IDLE);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (acc_rd) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // outputs of the access machine
    always_comb begin
        bus_ready  = 1'b0;
        bus_rvalid = 1'b0;
        unique case (state_q)
            BUS_IDLE: bus_ready  = 1'b1;
            BUS_RESP: bus_rvalid = 1'b1;
        endcase
    end

    always_comb begin
        strobe.soft_rst = acc_wr && (bus_addr == OFF_CTRL) && bus_wdata[0];
        strobe.ien_wr   = acc_wr && (bus_addr == OFF_IEN);
        strobe.idis_wr  = acc_wr && (bus_addr == OFF_IDIS);
        strobe.hold_rd  = acc_rd && (bus_addr == OFF_HOLD);
        strobe.stat_rd  = acc_rd && (bus_addr == OFF_ISTAT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            cfg_q  <= '0;
        end else if (acc_wr) begin
            if (bus_addr == OFF_MODE) mode_q <= bus_wdata;
            if (bus_addr == OFF_CFG)  cfg_q  <= bus_wdata;
        end
    end

    always_comb begin
        case (bus_addr)
            OFF_MODE:  rd_mux = mode_q;
            OFF_CFG:   rd_mux = cfg_q;
            OFF_HOLD:  rd_mux = fifo_empty ? '0 : hold_word;
            OFF_IMASK: rd_mux = DATA_W'(mask);
            OFF_ISTAT: rd_mux = DATA_W'(status);
            OFF_VER:   rd_mux = DATA_W'(VERSION);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (acc_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata  = rdata_q;
    assign chunk_code = mode_q[CHUNK_LSB +: CHUNK_W];

    // R13
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |=> !bus_rvalid);

    // R13
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_ready) |=> (bus_rvalid && !bus_ready));

    // R12
    wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_ready && bus_addr != OFF_MODE) |=> $stable(mode_q));

endmodule

// File: rtl/mic_rx_regs.sv
module mic_rx_regs
    import mic_rx_pkg::*;
#(
    parameter int          DEPTH   = 16,
    parameter int          CHAN_W  = 2,
    parameter logic [11:0] VERSION = 12'h2C5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [7:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic                bus_ready,
    output logic [31:0]         bus_rdata,
    output logic                bus_rvalid,
    output logic                irq,
    output logic                dma_req,
    input  logic                smp_valid,
    output logic                smp_ready,
    input  logic [23:0]         smp_data,
    input  logic [CHAN_W-1:0]   smp_chan
);
    localparam int ENTRY_W = SAMPLE_W + CHAN_W;
    localparam int CNT_W   = $clog2(DEPTH + 1);

    acc_strobe_t         strobe;
    logic [CHUNK_W-1:0]  chunk_code;
    logic [CHUNK_W-1:0]  chunk_thr;
    logic [ENTRY_W-1:0]  fifo_head;
    logic [CNT_W-1:0]    fifo_count;
    logic                fifo_empty, fifo_full;
    logic                chunk_lvl, udr_evt, ovr_evt;
    logic [DATA_W-1:0]   hold_word;
    logic [IRQ_N-1:0]    mask, status;

    mic_rx_fifo #(
        .DEPTH (DEPTH),
        .WIDTH (ENTRY_W)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (strobe.soft_rst),
        .push_valid (smp_valid),
        .push_data  ({smp_chan, smp_data}),
        .push_ready (smp_ready),
        .pop        (strobe.hold_rd),
        .head       (fifo_head),
        .count      (fifo_count),
        .empty      (fifo_empty),
        .full       (fifo_full)
    );

    assign hold_word = {TAG_W'(fifo_head[ENTRY_W-1:SAMPLE_W]), fifo_head[SAMPLE_W-1:0]};

    assign chunk_thr = (chunk_code == '0) ? CHUNK_W'(1) : chunk_code;
    assign chunk_lvl = (32'(fifo_count) >= 32'(chunk_thr));
    assign dma_req   = chunk_lvl;

    assign udr_evt = strobe.hold_rd && fifo_empty;
    assign ovr_evt = smp_valid && fifo_full;

    mic_rx_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (strobe.soft_rst),
        .ien_wr    (strobe.ien_wr),
        .idis_wr   (strobe.idis_wr),
        .wbits     (bus_wdata[IRQ_N-1:0]),
        .stat_rd   (strobe.stat_rd),
        .lvl_rdy   (!fifo_empty),
        .lvl_emp   (fifo_empty),
        .lvl_full  (fifo_full),
        .lvl_chunk (chunk_lvl),
        .udr_evt   (udr_evt),
        .ovr_evt   (ovr_evt),
        .mask      (mask),
        .status    (status),
        .irq       (irq)
    );

    mic_rx_bus #(
        .VERSION (VERSION)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_ready  (bus_ready),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .hold_word  (hold_word),
        .fifo_empty (fifo_empty),
        .mask       (mask),
        .status     (status),
        .strobe     (strobe),
        .chunk_code (chunk_code)
    );

    // R5
    udr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_ready && bus_addr == OFF_HOLD && fifo_empty)
        |=> status[IB_UDR]);

    // R4
    ovr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_ready && !strobe.soft_rst) |=> status[IB_OVR]);

    // R9
    dma_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> !fifo_empty);

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.soft_rst |=> (fifo_empty && !status[IB_OVR] && !status[IB_UDR]));

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

endmodule

// File: tb/mic_rx_regs_test.sv
`timescale 1ns/1ps
module mic_rx_regs_test;

    localparam logic [11:0] VER = 12'h2C5;
    localparam int N_VEC = 16;

    // {write, addr, wdata, expected read}
    localparam logic [72:0] VEC [N_VEC] = '{
        {1'b1, 8'h04, 32'h4000_0000, 32'h0},
        {1'b0, 8'h04, 32'h0,         32'h4000_0000},
        {1'b1, 8'h08, 32'h00AB_CDEF, 32'h0},
        {1'b0, 8'h08, 32'h0,         32'h00AB_CDEF},
        {1'b0, 8'h20, 32'h0,         32'h0000_0002},
        {1'b1, 8'h14, 32'h0000_003F, 32'h0},
        {1'b0, 8'h1C, 32'h0,         32'h0000_003F},
        {1'b1, 8'h18, 32'h0000_0005, 32'h0},
        {1'b0, 8'h1C, 32'h0,         32'h0000_003A},
        {1'b1, 8'h1C, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 8'h1C, 32'h0,         32'h0000_003A},
        {1'b0, 8'h50, 32'h0,         {20'h0, VER}},
        {1'b0, 8'h00, 32'h0,         32'h0},
        {1'b0, 8'h14, 32'h0,         32'h0},
        {1'b0, 8'h18, 32'h0,         32'h0},
        {1'b0, 8'h24, 32'h0,         32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, bus_rvalid, irq, dma_req, smp_ready;
    logic [31:0] bus_rdata;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_data = '0;
    logic [1:0]  smp_chan = '0;

    int checks = 0;
    int errors = 0;
    logic [31:0] rd;

    always #2 clk = ~clk;

    mic_rx_regs #(.DEPTH(16), .CHAN_W(2), .VERSION(VER)) uut (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .irq(irq), .dma_req(dma_req),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data), .smp_chan(smp_chan)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] samp(input int i);
        return 24'h10_0000 + 24'(i) * 24'h01_0203;
    endfunction

    function automatic logic [31:0] word(input int i);
        return {6'b0, 2'(i % 4), samp(i)};
    endfunction

    task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        d = bus_rdata;
        if (!bus_rvalid) chk(1'b0, "R13 rvalid", 32'(bus_rvalid), 32'h1);
        bus_sel = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic push(input int i);
        smp_valid = 1'b1; smp_data = samp(i); smp_chan = 2'(i % 4);
        @(posedge clk); @(negedge clk);
        smp_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(bus_rdata == 0, "R1 rdata", bus_rdata, 0);
        chk(!irq && !dma_req, "R1 irq/dma", {irq, dma_req}, 0);
        chk(smp_ready && bus_ready, "R1 ready", {smp_ready, bus_ready}, 32'h3);
        rst_n = 1'b1;
        @(negedge clk);
        bread(8'h20, rd);
        chk(rd == 32'h2, "R1 status", rd, 32'h2);

        // table walk: R6 R11 R12
        for (int k = 0; k < N_VEC; k++) begin
            if (VEC[k][72]) begin
                bwrite(VEC[k][71:64], VEC[k][63:32]);
            end else begin
                bread(VEC[k][71:64], rd);
                chk(rd == VEC[k][31:0], "R6/R11/R12 table", rd, VEC[k][31:0]);
            end
        end
        bwrite(8'h18, 32'h3F);
        chk(!irq, "R7 irq masked off", irq, 0);

        // R9 chunk 4, R2 ordering
        for (int i = 0; i < 3; i++) push(i);
        chk(!dma_req, "R9 below chunk", dma_req, 0);
        bread(8'h20, rd);
        chk(rd == 32'h01, "R8 status 3 entries", rd, 32'h01);
        push(3);
        chk(dma_req, "R9 at chunk", dma_req, 1);
        bread(8'h20, rd);
        chk(rd == 32'h09, "R9 status chunk", rd, 32'h09);
        for (int i = 0; i < 4; i++) begin
            bread(8'h0C, rd);
            chk(rd == word(i), "R2 hold word", rd, word(i));
        end
        bread(8'h20, rd);
        chk(rd == 32'h02, "R2 drained", rd, 32'h02);

        // R3 R4 full and overrun
        for (int i = 0; i < 16; i++) push(i);
        chk(!smp_ready, "R3 ready low when full", smp_ready, 0);
        bread(8'h20, rd);
        chk(rd == 32'h0D, "R3 full status", rd, 32'h0D);
        push(99);
        bread(8'h20, rd);
        chk(rd == 32'h2D, "R4 overrun latched", rd, 32'h2D);
        bread(8'h20, rd);
        chk(rd == 32'h0D, "R8 read clears", rd, 32'h0D);
        for (int i = 0; i < 16; i++) begin
            bread(8'h0C, rd);
            chk(rd == word(i), "R3/R4 drain order", rd, word(i));
        end
        // R5 underrun
        bread(8'h0C, rd);
        chk(rd == 0, "R5 empty read data", rd, 0);
        bread(8'h20, rd);
        chk(rd == 32'h12, "R5 underrun latched", rd, 32'h12);
        bread(8'h20, rd);
        chk(rd == 32'h02, "R8 underrun cleared", rd, 32'h02);

        // R7 irq from underrun
        bwrite(8'h14, 32'h10);
        chk(!irq, "R7 irq idle", irq, 0);
        bread(8'h0C, rd);
        chk(irq, "R7 irq on underrun", irq, 1);
        bread(8'h20, rd);
        chk(!irq, "R7 irq after clear", irq, 0);
        bwrite(8'h18, 32'h10);
        bwrite(8'h14, 32'h20);

        // R8 coincident status read and overrun
        for (int i = 0; i < 16; i++) push(i);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h20;
        smp_valid = 1'b1; smp_data = 24'hABCDEF;
        @(posedge clk); @(negedge clk);
        chk(bus_rvalid && !bus_ready, "R13 resp cycle", {bus_rvalid, bus_ready}, 32'h2);
        chk(bus_rdata == 32'h0D, "R8 coincident read data", bus_rdata, 32'h0D);
        bus_sel = 1'b0; smp_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(irq, "R8 event wins, irq", irq, 1);
        bread(8'h20, rd);
        chk(rd == 32'h2D, "R8 event wins over clear", rd, 32'h2D);
        push(50);
        chk(irq, "R7 overrun irq", irq, 1);

        // R10 soft reset
        bwrite(8'h00, 32'h1);
        chk(!irq && smp_ready, "R10 after soft reset", {irq, smp_ready}, 32'h1);
        bread(8'h20, rd);
        chk(rd == 32'h02, "R10 status", rd, 32'h02);
        bread(8'h1C, rd);
        chk(rd == 32'h20, "R10 mask kept", rd, 32'h20);
        bread(8'h04, rd);
        chk(rd == 32'h4000_0000, "R10 mode kept", rd, 32'h4000_0000);

        // R9 threshold 0 acts as 1, threshold 8
        bwrite(8'h04, 32'h0);
        push(1);
        chk(dma_req, "R9 zero as one", dma_req, 1);
        bwrite(8'h00, 32'h1);
        bwrite(8'h04, 32'h8000_0000);
        for (int i = 0; i < 7; i++) push(i);
        chk(!dma_req, "R9 seven of eight", dma_req, 0);
        push(7);
        chk(dma_req, "R9 eight of eight", dma_req, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule